// File: doc/BRIEF.md
# Timer Status Flags with Armed Two-Step Clear

This block is the flag and interrupt section of a 16-bit free-running timer. It contains the counter, an input-capture edge detector with its capture register, and an output-compare matcher. It keeps three event flags: capture, compare and counter wrap. Software reaches the block over a byte-wide register bus with an address, a read strobe and a write strobe. Read data is registered and appears one cycle after the strobe.

A flag is never cleared by a single access. First, a read of the status register has to observe the flag at 1. This sets a private arm bit for that flag. Second, software accesses the data register that belongs to the flag. An access that is not preceded by such a status read leaves the flag untouched.

The counter can be read through two byte pairs. The main pair clears the wrap flag when it is armed. The alternate pair returns the same count and never touches the flag. Each pair has its own low-byte latch, so a high-then-low read gives a coherent 16-bit value.

Top module: `tmr_flag_unit`

## Requirements
- R1: Reading address 0x13 returns the status byte, one cycle after the read strobe. Bit 7 is the capture flag, bit 6 the compare flag, bit 5 the wrap flag, and bits 4 to 0 read 0. After reset all three flags are 0.
- R2: Bit 0 of the control register at 0x12 selects the capture edge (1 = rising, 0 = falling). The capture input passes two synchronizer stages. When the selected edge is seen, the capture flag sets and the capture register (high byte 0x14, low byte 0x15) takes the counter value of the detection cycle. This is the count two clock edges after the input changes. The other edge sets nothing.
- R3: The compare flag sets on the clock edge at which the counter equals the 16-bit compare value. The compare value is written at 0x16 (high) and 0x17 (low) and resets to 0xFFFF.
- R4: The counter starts at 0 after reset and advances by one every clock. The wrap flag sets on the edge where the counter goes from 0xFFFF to 0.
- R5: After an arming status read, a read of 0x15 clears the capture flag.
- R6: After an arming status read, a write to 0x17 clears the compare flag.
- R7: After an arming status read, a read of the main counter low byte (0x19) clears the wrap flag.
- R8: A flag's arm bit is set only by a status read that sees that flag at 1. It is consumed by the flag's data-register access. Without it, that access leaves the flag set. A high-byte access never clears a flag.
- R9: The alternate pair (0x1A high, 0x1B low) returns the same count as the main pair. Reading it never clears the wrap flag.
- R10: Reading a high byte (0x18 or 0x1A) latches that pair's low byte. The next low-byte read of the same pair returns the latched value. With no pending latch, a low-byte read returns the live count. The two pairs latch independently.
- R11: The interrupt outputs are bit 2 for capture, bit 1 for compare and bit 0 for wrap. Each equals its flag ANDed with its enable, one cycle later. The enables are control bits 7 (capture), 6 (compare) and 5 (wrap).
- R12: When a flag's set condition and its armed clear occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the strobe |
| cap_pin | input | 1 | Capture input, asynchronous |
| irq_o | output | 3 | Per-flag interrupt requests {capture, compare, wrap} |

## Verification
The assertions check on every cycle that the wrap and compare flags rise only on a counter wrap or a compare match. They also check that the wrap flag falls only on an armed main low-byte read, that arms rise only over a set flag, that a set always beats a clear, that alternate reads leave the wrap flag alone, that the status pad bits stay 0, and that each interrupt follows its enabled flag with one cycle of lag. What only the directed scenarios can show is the data path: the captured count for a given input edge, the coherent values from the two latched counter pairs, and the full unarmed-then-armed clearing sequence of each flag. The scenarios also land a cleared read exactly on a counter wrap.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int ADDR_W = 8;
  localparam int NFLAG  = 3;

  // flag index inside the flag vector
  localparam int FI_OVF = 0;
  localparam int FI_OCM = 1;
  localparam int FI_ICP = 2;

  // register byte addresses
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h12;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h13;
  localparam logic [ADDR_W-1:0] A_CAPH = 8'h14;
  localparam logic [ADDR_W-1:0] A_CAPL = 8'h15;
  localparam logic [ADDR_W-1:0] A_CMPH = 8'h16;
  localparam logic [ADDR_W-1:0] A_CMPL = 8'h17;
  localparam logic [ADDR_W-1:0] A_CNTH = 8'h18;
  localparam logic [ADDR_W-1:0] A_CNTL = 8'h19;
  localparam logic [ADDR_W-1:0] A_ALTH = 8'h1A;
  localparam logic [ADDR_W-1:0] A_ALTL = 8'h1B;
endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + 1'b1;
  end

  // high during the last count before the wrap
  assign wrap_o = &cnt_o;
endmodule

// File: rtl/tmr_edge_capture.sv
module tmr_edge_capture #(
  parameter int W     = 16,
  parameter int SYNC  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin_i,
  input  logic         rise_sel_i,
  input  logic [W-1:0] cnt_i,
  output logic         hit_o,
  output logic [W-1:0] cap_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            s_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign s_now = sync_q[SYNC-1];
  assign hit_o = rise_sel_i ? (s_now & ~prev_q) : (~s_now & prev_q);

  always_ff @(posedge clk) begin
    if (rst)        cap_o <= '0;
    else if (hit_o) cap_o <= cnt_i;
  end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic acc_i,
  output logic flag_o,
  output logic arm_o
);
  logic flag_n;
  logic arm_n;

  always_comb begin
    // set has priority over an armed clear
    flag_n = set_i | (flag_o & ~(arm_o & acc_i));
    arm_n  = arm_o;
    if (stat_rd_i && flag_o) arm_n = 1'b1;
    else if (acc_i)          arm_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      arm_o  <= 1'b0;
    end else begin
      flag_o <= flag_n;
      arm_o  <= arm_n;
    end
  end
endmodule

// File: rtl/tmr_pair_latch.sv
module tmr_pair_latch #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hi_rd_i,
  input  logic           lo_rd_i,
  input  logic [W-1:0]   cnt_i,
  output logic [W/2-1:0] lo_val_o
);
  localparam int H = W / 2;

  logic [H-1:0] lat_q;
  logic         lat_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      lat_v <= 1'b0;
    end else if (hi_rd_i) begin
      lat_q <= cnt_i[H-1:0];
      lat_v <= 1'b1;
    end else if (lo_rd_i) begin
      lat_v <= 1'b0;
    end
  end

  assign lo_val_o = lat_v ? lat_q : cnt_i[H-1:0];
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [CNT_W/2-1:0] bus_wdata,
  output logic [CNT_W/2-1:0] bus_rdata,
  input  logic               cap_pin,
  output logic [NFLAG-1:0]   irq_o
);
  localparam int BYTE_W = CNT_W / 2;
  localparam int NPAIR  = 2;

  logic [CNT_W-1:0]  cnt_w;
  logic              wrap_w;
  logic              hit_w;
  logic [CNT_W-1:0]  cap_w;
  logic [CNT_W-1:0]  cmp_q;
  logic              rise_sel_q;
  logic [NFLAG-1:0]  ie_v;
  logic [NFLAG-1:0]  set_v;
  logic [NFLAG-1:0]  acc_v;
  logic [NFLAG-1:0]  flag_v;
  logic [NFLAG-1:0]  arm_v;
  logic              stat_rd;
  logic [NPAIR-1:0]  hi_rd;
  logic [NPAIR-1:0]  lo_rd;
  logic [BYTE_W-1:0] lo_val [NPAIR];
  logic [BYTE_W-1:0] stat_byte;
  logic [BYTE_W-1:0] ctrl_byte;
  logic [BYTE_W-1:0] rd_mux;

  tmr_free_counter #(.W(CNT_W)) ctr_i (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  tmr_edge_capture #(.W(CNT_W), .SYNC(SYNC_STAGES)) cap_i (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (cap_pin),
    .rise_sel_i (rise_sel_q),
    .cnt_i      (cnt_w),
    .hit_o      (hit_w),
    .cap_o      (cap_w)
  );

  // control and compare registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_sel_q <= 1'b0;
      ie_v       <= '0;
      cmp_q      <= '1;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        rise_sel_q   <= bus_wdata[0];
        ie_v[FI_ICP] <= bus_wdata[BYTE_W-1];
        ie_v[FI_OCM] <= bus_wdata[BYTE_W-2];
        ie_v[FI_OVF] <= bus_wdata[BYTE_W-3];
      end
      if (bus_addr == A_CMPH) cmp_q[CNT_W-1:BYTE_W] <= bus_wdata;
      if (bus_addr == A_CMPL) cmp_q[BYTE_W-1:0]     <= bus_wdata;
    end
  end

  // flag set and clear sources
  assign stat_rd       = bus_rd && (bus_addr == A_STAT);
  assign set_v[FI_OVF] = wrap_w;
  assign set_v[FI_OCM] = (cnt_w == cmp_q);
  assign set_v[FI_ICP] = hit_w;
  assign acc_v[FI_OVF] = bus_rd && (bus_addr == A_CNTL);
  assign acc_v[FI_OCM] = bus_wr && (bus_addr == A_CMPL);
  assign acc_v[FI_ICP] = bus_rd && (bus_addr == A_CAPL);

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    tmr_flag_cell cell_i (
      .clk       (clk),
      .rst       (rst),
      .set_i     (set_v[f]),
      .stat_rd_i (stat_rd),
      .acc_i     (acc_v[f]),
      .flag_o    (flag_v[f]),
      .arm_o     (arm_v[f])
    );
  end

  // counter read pairs: 0 = main, 1 = alternate
  assign hi_rd[0] = bus_rd && (bus_addr == A_CNTH);
  assign lo_rd[0] = bus_rd && (bus_addr == A_CNTL);
  assign hi_rd[1] = bus_rd && (bus_addr == A_ALTH);
  assign lo_rd[1] = bus_rd && (bus_addr == A_ALTL);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    tmr_pair_latch #(.W(CNT_W)) lat_i (
      .clk      (clk),
      .rst      (rst),
      .hi_rd_i  (hi_rd[p]),
      .lo_rd_i  (lo_rd[p]),
      .cnt_i    (cnt_w),
      .lo_val_o (lo_val[p])
    );
  end

  always_comb begin
    stat_byte           = '0;
    stat_byte[BYTE_W-1] = flag_v[FI_ICP];
    stat_byte[BYTE_W-2] = flag_v[FI_OCM];
    stat_byte[BYTE_W-3] = flag_v[FI_OVF];
    ctrl_byte           = '0;
    ctrl_byte[BYTE_W-1] = ie_v[FI_ICP];
    ctrl_byte[BYTE_W-2] = ie_v[FI_OCM];
    ctrl_byte[BYTE_W-3] = ie_v[FI_OVF];
    ctrl_byte[0]        = rise_sel_q;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  rd_mux = ctrl_byte;
      A_STAT:  rd_mux = stat_byte;
      A_CAPH:  rd_mux = cap_w[CNT_W-1:BYTE_W];
      A_CAPL:  rd_mux = cap_w[BYTE_W-1:0];
      A_CMPH:  rd_mux = cmp_q[CNT_W-1:BYTE_W];
      A_CMPL:  rd_mux = cmp_q[BYTE_W-1:0];
      A_CNTH:  rd_mux = cnt_w[CNT_W-1:BYTE_W];
      A_CNTL:  rd_mux = lo_val[0];
      A_ALTH:  rd_mux = cnt_w[CNT_W-1:BYTE_W];
      A_ALTL:  rd_mux = lo_val[1];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_o <= flag_v & ie_v;
    end
  end
endmodule

// File: rtl/tmr_flag_unit_chk.sv
module tmr_flag_unit_chk
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rd,
  input logic [CNT_W/2-1:0] bus_rdata,
  input logic [NFLAG-1:0]   irq_o,
  input logic [NFLAG-1:0]   flag_v,
  input logic [NFLAG-1:0]   arm_v,
  input logic [NFLAG-1:0]   ie_v,
  input logic [CNT_W-1:0]   cnt_w,
  input logic [CNT_W-1:0]   cmp_q
);
  localparam int BYTE_W = CNT_W / 2;

  assert_stat_pad_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == A_STAT) |-> bus_rdata[BYTE_W-4:0] == '0);

  assert_ocf_on_match_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_v[FI_OCM]) |-> $past(cnt_w == cmp_q));

  assert_ovf_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_v[FI_OVF]) |-> $past(&cnt_w));

  assert_ovf_clear_armed_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_v[FI_OVF]) |-> $past(arm_v[FI_OVF] && bus_rd && bus_addr == A_CNTL));

  assert_arm_over_flag_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_v[FI_OVF]) |-> $past(flag_v[FI_OVF]));

  assert_alt_keeps_ovf_R9: assert property (@(posedge clk) disable iff (rst)
    $past(flag_v[FI_OVF] && bus_rd && (bus_addr == A_ALTH || bus_addr == A_ALTL))
    |-> flag_v[FI_OVF]);

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(flag_v & ie_v));

  assert_set_wins_ovf_R12: assert property (@(posedge clk) disable iff (rst)
    $past(&cnt_w) |-> flag_v[FI_OVF]);

  assert_set_wins_ocm_R12: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_w == cmp_q) |-> flag_v[FI_OCM]);
endmodule

bind tmr_flag_unit tmr_flag_unit_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .flag_v    (flag_v),
  .arm_v     (arm_v),
  .ie_v      (ie_v),
  .cnt_w     (cnt_w),
  .cmp_q     (cmp_q)
);

// File: tb/tmr_flag_unit_tb_top.sv
module tmr_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pin = 1'b0;
  logic [2:0] irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  tmr_flag_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (addr),
    .bus_rd    (rd),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .cap_pin   (pin),
    .irq_o     (irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a negedge
  task automatic bus_read(input logic [7:0] a, output logic [7:0] d, output int c);
    c = cyc; addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc != t) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d; int c;
    bus_read(8'h13, d, c);
    check(d == 8'h00, "R1 status after reset", d, 0);
    check(irq == 3'b000, "R11 irq after reset", irq, 0);
  endtask

  task automatic t_pairs;
    logic [7:0] d; int c1, c2, c3, cx;
    bus_read(8'h18, d, c1);
    check(d == 8'((c1 >> 8) & 255), "R10 main high", d, (c1 >> 8) & 255);
    idle(5);
    bus_read(8'h19, d, cx);
    check(d == 8'(c1 & 255), "R10 main low latched", d, c1 & 255);
    bus_read(8'h1A, d, c2);
    check(d == 8'((c2 >> 8) & 255), "R9 alt high", d, (c2 >> 8) & 255);
    idle(3);
    bus_read(8'h18, d, c3);
    idle(2);
    bus_read(8'h1B, d, cx);
    check(d == 8'(c2 & 255), "R10 alt low own latch", d, c2 & 255);
    bus_read(8'h19, d, cx);
    check(d == 8'(c3 & 255), "R10 main low own latch", d, c3 & 255);
    bus_read(8'h19, d, cx);
    check(d == 8'(cx & 255), "R10 main low live", d, cx & 255);
  endtask

  task automatic t_capture;
    logic [7:0] d; int c, c0;
    bus_write(8'h12, 8'h80);          // falling edge, capture irq on
    pin = 1'b1;
    idle(6);
    bus_read(8'h13, d, c);
    check(d[7] == 1'b0, "R2 wrong edge ignored", d[7], 0);
    c0 = cyc; pin = 1'b0;
    idle(6);
    check(irq[2] == 1'b1, "R11 capture irq", irq[2], 1);
    bus_read(8'h15, d, c);
    check(d == 8'((c0 + 2) & 255), "R2 capture low", d, (c0 + 2) & 255);
    bus_read(8'h13, d, c);
    check(d[7] == 1'b1, "R8 unarmed low read keeps flag", d[7], 1);
    bus_read(8'h14, d, c);
    check(d == 8'(((c0 + 2) >> 8) & 255), "R2 capture high", d, ((c0 + 2) >> 8) & 255);
    bus_read(8'h15, d, c);
    bus_read(8'h13, d, c);
    check(d[7] == 1'b0, "R5 armed low read clears", d[7], 0);
    idle(1);
    check(irq[2] == 1'b0, "R11 capture irq dropped", irq[2], 0);
    // status read with flag at 0 must not arm
    bus_write(8'h12, 8'h81);          // rising edge
    bus_read(8'h13, d, c);
    pin = 1'b1;
    idle(6);
    bus_read(8'h15, d, c);
    bus_read(8'h13, d, c);
    check(d[7] == 1'b1, "R8 arm needs flag set", d[7], 1);
    bus_read(8'h15, d, c);
    bus_read(8'h13, d, c);
    check(d[7] == 1'b0, "R5 clear after re-arm", d[7], 0);
  endtask

  task automatic t_compare;
    logic [7:0] d; int c, tgt;
    bus_write(8'h12, 8'h40);
    tgt = cyc + 40;
    bus_write(8'h16, 8'((tgt >> 8) & 255));
    bus_write(8'h17, 8'(tgt & 255));
    wait_until(tgt);
    bus_read(8'h13, d, c);
    check(d[6] == 1'b0, "R3 flag clear before match edge", d[6], 0);
    bus_write(8'h17, 8'(tgt & 255));
    bus_read(8'h13, d, c);
    check(d[6] == 1'b1, "R8 unarmed write keeps compare flag", d[6], 1);
    check(irq[1] == 1'b1, "R11 compare irq", irq[1], 1);
    bus_write(8'h16, 8'((tgt >> 8) & 255));
    bus_read(8'h13, d, c);
    check(d[6] == 1'b1, "R8 high write keeps compare flag", d[6], 1);
    bus_write(8'h17, 8'(tgt & 255));
    bus_read(8'h13, d, c);
    check(d[6] == 1'b0, "R6 armed write clears", d[6], 0);
    idle(1);
    check(irq[1] == 1'b0, "R11 compare irq dropped", irq[1], 0);
  endtask

  task automatic t_overflow;
    logic [7:0] d, dh; int c, ch;
    bus_write(8'h12, 8'h20);
    wait_until(65535);
    bus_read(8'h13, d, c);
    check(d[5] == 1'b0, "R4 flag clear before wrap edge", d[5], 0);
    bus_read(8'h19, d, c);
    bus_read(8'h13, d, c);
    check(d[5] == 1'b1, "R4/R8 wrap flag set, unarmed read kept it", d[5], 1);
    check(irq[0] == 1'b1, "R11 wrap irq", irq[0], 1);
    bus_read(8'h1A, dh, ch);
    bus_read(8'h1B, d, c);
    check(d == 8'(ch & 255), "R9 alt coherent low", d, ch & 255);
    bus_read(8'h13, d, c);
    check(d[5] == 1'b1, "R9 alt read keeps wrap flag", d[5], 1);
    wait_until(131071);
    bus_read(8'h19, d, c);            // armed clear on the wrap edge
    bus_read(8'h13, d, c);
    check(d[5] == 1'b1, "R12 set wins over clear", d[5], 1);
    bus_read(8'h19, d, c);
    bus_read(8'h13, d, c);
    check(d[5] == 1'b0, "R7 armed low read clears", d[5], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pairs();
    t_capture();
    t_compare();
    t_overflow();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule